// File: doc/BRIEF.md
# Quad Wiper Position Register Bank

This block keeps the wiper setting of a bank of digitally controlled potentiometers, one 8-bit volatile position per pot. Each position is decoded into a one-hot vector of 256 tap enables, one per resistor switch. Tap 0 connects the wiper to the low end of the array and tap 255 connects it to the high end. The command parser and the nonvolatile store sit outside. The parser presents load strobes and step pulses. The store presents the four saved values of every pot as one flat input.

A position changes in four ways:
- After reset, a one-cycle power-up recall copies each pot's saved slot 0 into its position.
- A host write loads a given byte into one pot.
- A transfer copies one saved slot into one pot. The global form copies that slot index into every pot at once.
- During a step frame, each step pulse moves the framed pot one tap up or down. The pot is the one chosen when the frame opened.

A small controller with three states sequences these sources:
- **BOOT** is the reset state. It performs the recall and always moves to IDLE on the next clock.
- **IDLE** accepts loads. It moves to STEP when `step_en` is high and latches `step_pot` on that transition.
- **STEP** accepts loads and step pulses. It returns to IDLE when `step_en` drops.

Top module: `wcr_bank`

## Requirements
- R1: While `rst_n` is low every position reads 00h. At the first rising clock edge after reset is released, every pot p takes saved slot 0 of pot p. Host writes and transfers on that edge are ignored.
- R2: For every pot, exactly one of its 256 tap enables is high at all times. That enable is bit `pos` of the pot's slice `tap_sel[p*256 +: 256]`, so 00h drives bit 0 (low end) and FFh drives bit 255 (high end).
- R3: A host write (`host_wr` high) loads `host_data` into pot `host_pot` at the next edge. Other pots keep their value.
- R4: A single transfer (`xfer_ld` high, `xfer_all` low) loads saved slot `xfer_sel` of pot `xfer_pot` into that pot at the next edge. Other pots keep their value.
- R5: A global transfer (`xfer_ld` and `xfer_all` high) loads saved slot `xfer_sel` of each pot into that pot, for all pots on the same edge.
- R6: A frame opens on the edge that samples `step_en` high in IDLE and latches `step_pot`. On each later edge in the frame, a high `step_pulse` moves the framed pot up one tap if `step_up` is 1 and down one tap if it is 0.
- R7: Stepping saturates. An up step at FFh and a down step at 00h leave the position unchanged.
- R8: Step pulses have no effect outside a frame, including the edge that opens it. Changing `step_pot` while a frame is open does not change which pot steps.
- R9: If a load and a step target the same pot on the same edge, the load value is taken and the step is dropped.
- R10: If a host write and a transfer target the same pot on the same edge, the host write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Release starts the power-up recall |
| host_wr | input | 1 | Host write strobe |
| host_pot | input | 2 | Pot targeted by the host write |
| host_data | input | 8 | Position value for the host write |
| xfer_ld | input | 1 | Transfer strobe from a saved slot |
| xfer_all | input | 1 | 1 = global transfer to all pots |
| xfer_pot | input | 2 | Pot targeted by a single transfer |
| xfer_sel | input | 2 | Saved slot index for the transfer |
| step_en | input | 1 | Step frame active (level) |
| step_pot | input | 2 | Pot to step, latched when the frame opens |
| step_pulse | input | 1 | One step per high cycle |
| step_up | input | 1 | 1 = toward the high end, 0 = toward the low end |
| stored_regs | input | 128 | Saved slots; slot r of pot p at bits [(p*4+r)*8 +: 8] |
| wiper_pos | output | 32 | Positions; pot p at bits [p*8 +: 8] |
| tap_sel | output | 1024 | One-hot tap enables; pot p at bits [p*256 +: 256] |

## Verification
The bench targets these corner cases and the failure each one exposes:
- **Both range ends.** A stepper that wraps would jump from FFh to 00h, or the reverse, and move the tap enable to the opposite terminal.
- **Same-edge collisions.** Load against step and host write against transfer on one pot: a wrong priority leaves a stepped or transferred value where the host byte belongs.
- **Frame edges.** A pulse on the opening edge, or a `step_pot` change mid-frame, would move the wrong pot or move one early if the latch or the frame entry were wrong.
- **Recall edge.** Loads on the recall edge would override slot 0 if the boot state did not take precedence. A long seeded random mix then cross-checks all pots and tap vectors every cycle.

// File: rtl/wcr_pkg.sv
package wcr_pkg;
    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_IDLE = 2'd1,
        ST_STEP = 2'd2
    } wcr_state_e;
endpackage

// File: rtl/wcr_cell.sv
module wcr_cell #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] ld_val,
    input  logic             inc_en,
    input  logic             dec_en,
    output logic [WIDTH-1:0] pos
);
    localparam logic [WIDTH-1:0] TOP = '1;
    localparam logic [WIDTH-1:0] BOT = '0;

    logic [WIDTH-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= BOT;
        end else if (ld_en) begin
            pos_q <= ld_val;
        end else if (inc_en && pos_q != TOP) begin
            pos_q <= pos_q + 1'b1;
        end else if (dec_en && pos_q != BOT) begin
            pos_q <= pos_q - 1'b1;
        end
    end

    assign pos = pos_q;

    // R9: a load always lands, whatever step is requested
    p_load_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> pos_q == $past(ld_val));

    // R7: saturation at both ends
    p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !ld_en && pos_q == TOP) |=> pos_q == TOP);
    p_sat_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !ld_en && pos_q == BOT) |=> pos_q == BOT);

    // R6: a single step moves by exactly one tap
    p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !ld_en && pos_q != TOP) |=> pos_q == $past(pos_q) + 1'b1);
    p_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !ld_en && !inc_en && pos_q != BOT) |=> pos_q == $past(pos_q) - 1'b1);

    // R3: with no request the position is held
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !inc_en && !dec_en) |=> $stable(pos_q));
endmodule

// File: rtl/wcr_tap_decode.sv
module wcr_tap_decode #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]      pos,
    output logic [(1<<WIDTH)-1:0] tap
);
    localparam int TAPS = 1 << WIDTH;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign tap[k] = (pos == WIDTH'(k));
    end
endmodule

// File: rtl/wcr_ctrl.sv
module wcr_ctrl
    import wcr_pkg::*;
#(
    parameter int NUM_POTS = 4,
    parameter int NUM_REGS = 4,
    parameter int WIDTH    = 8,
    localparam int POT_W   = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
    localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               host_wr,
    input  logic [POT_W-1:0]                   host_pot,
    input  logic [WIDTH-1:0]                   host_data,
    input  logic                               xfer_ld,
    input  logic                               xfer_all,
    input  logic [POT_W-1:0]                   xfer_pot,
    input  logic [REG_W-1:0]                   xfer_sel,
    input  logic                               step_en,
    input  logic [POT_W-1:0]                   step_pot,
    input  logic                               step_pulse,
    input  logic                               step_up,
    input  logic [NUM_POTS*NUM_REGS*WIDTH-1:0] stored_regs,
    output logic [NUM_POTS-1:0]                ld_en,
    output logic [NUM_POTS*WIDTH-1:0]          ld_val,
    output logic [NUM_POTS-1:0]                inc_en,
    output logic [NUM_POTS-1:0]                dec_en
);
    wcr_state_e       state_q, state_d;
    logic [POT_W-1:0] frame_pot_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_BOOT;
            frame_pot_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && step_en) begin
                frame_pot_q <= step_pot;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: state_d = ST_IDLE;
            ST_IDLE: if (step_en)  state_d = ST_STEP;
            ST_STEP: if (!step_en) state_d = ST_IDLE;
            default: state_d = ST_BOOT;
        endcase
    end

    // outputs: per-pot load and step requests
    always_comb begin
        logic hit;
        ld_en  = '0;
        ld_val = '0;
        inc_en = '0;
        dec_en = '0;
        unique case (state_q)
            ST_BOOT: begin
                for (int p = 0; p < NUM_POTS; p++) begin
                    ld_en[p]                 = 1'b1;
                    ld_val[p*WIDTH +: WIDTH] = stored_regs[(p*NUM_REGS)*WIDTH +: WIDTH];
                end
            end
            ST_IDLE, ST_STEP: begin
                for (int p = 0; p < NUM_POTS; p++) begin
                    hit = 1'b0;
                    if (host_wr && host_pot == POT_W'(p)) begin
                        hit                      = 1'b1;
                        ld_val[p*WIDTH +: WIDTH] = host_data;
                    end else if (xfer_ld && (xfer_all || xfer_pot == POT_W'(p))) begin
                        hit                      = 1'b1;
                        ld_val[p*WIDTH +: WIDTH] =
                            stored_regs[(p*NUM_REGS + int'(xfer_sel))*WIDTH +: WIDTH];
                    end
                    ld_en[p] = hit;
                    if (state_q == ST_STEP && step_pulse && !hit &&
                        frame_pot_q == POT_W'(p)) begin
                        inc_en[p] = step_up;
                        dec_en[p] = !step_up;
                    end
                end
            end
            default: ;
        endcase
    end

    // R1: the recall state lasts exactly one cycle
    p_boot_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BOOT |=> state_q == ST_IDLE);

    // R6: entering a frame latches the requested pot
    p_frame_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && step_en) |=>
            (state_q == ST_STEP && frame_pot_q == $past(step_pot)));

    // R8: the framed pot does not change while the frame stays open
    p_frame_pot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && step_en) |=> $stable(frame_pot_q));

    // R8: no step request leaves the controller outside a frame
    p_no_step_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STEP) |-> (inc_en == '0 && dec_en == '0));
endmodule

// File: rtl/wcr_bank.sv
module wcr_bank #(
    parameter int NUM_POTS = 4,
    parameter int NUM_REGS = 4,
    parameter int WIDTH    = 8,
    localparam int POT_W   = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
    localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int TAPS    = 1 << WIDTH
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               host_wr,
    input  logic [POT_W-1:0]                   host_pot,
    input  logic [WIDTH-1:0]                   host_data,
    input  logic                               xfer_ld,
    input  logic                               xfer_all,
    input  logic [POT_W-1:0]                   xfer_pot,
    input  logic [REG_W-1:0]                   xfer_sel,
    input  logic                               step_en,
    input  logic [POT_W-1:0]                   step_pot,
    input  logic                               step_pulse,
    input  logic                               step_up,
    input  logic [NUM_POTS*NUM_REGS*WIDTH-1:0] stored_regs,
    output logic [NUM_POTS*WIDTH-1:0]          wiper_pos,
    output logic [NUM_POTS*TAPS-1:0]           tap_sel
);
    logic [NUM_POTS-1:0]       ld_en, inc_en, dec_en;
    logic [NUM_POTS*WIDTH-1:0] ld_val;

    wcr_ctrl #(
        .NUM_POTS (NUM_POTS),
        .NUM_REGS (NUM_REGS),
        .WIDTH    (WIDTH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_pot    (host_pot),
        .host_data   (host_data),
        .xfer_ld     (xfer_ld),
        .xfer_all    (xfer_all),
        .xfer_pot    (xfer_pot),
        .xfer_sel    (xfer_sel),
        .step_en     (step_en),
        .step_pot    (step_pot),
        .step_pulse  (step_pulse),
        .step_up     (step_up),
        .stored_regs (stored_regs),
        .ld_en       (ld_en),
        .ld_val      (ld_val),
        .inc_en      (inc_en),
        .dec_en      (dec_en)
    );

    for (genvar g = 0; g < NUM_POTS; g++) begin : g_pot
        logic [WIDTH-1:0] pos;
        logic [TAPS-1:0]  tap;

        wcr_cell #(.WIDTH(WIDTH)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_en  (ld_en[g]),
            .ld_val (ld_val[g*WIDTH +: WIDTH]),
            .inc_en (inc_en[g]),
            .dec_en (dec_en[g]),
            .pos    (pos)
        );

        wcr_tap_decode #(.WIDTH(WIDTH)) u_dec (
            .pos (pos),
            .tap (tap)
        );

        assign wiper_pos[g*WIDTH +: WIDTH] = pos;
        assign tap_sel[g*TAPS +: TAPS]     = tap;

        // R2: exactly one switch closed, and it is the one the position names
        p_one_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tap) == 1);
        p_tap_at_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tap[pos] == 1'b1);
    end
endmodule

// File: tb/wcr_bank_tb.sv
module wcr_bank_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          host_wr = 0, xfer_ld = 0, xfer_all = 0, step_en = 0;
    logic          step_pulse = 0, step_up = 0;
    logic [1:0]    host_pot = 0, xfer_pot = 0, xfer_sel = 0, step_pot = 0;
    logic [7:0]    host_data = 0;
    logic [127:0]  stored_regs;
    logic [31:0]   wiper_pos;
    logic [1023:0] tap_sel;

    logic [7:0] sreg [4][4];
    logic [7:0] m_pos [4];
    bit         m_boot = 1'b1, m_frame = 1'b0;
    logic [1:0] m_fpot = 0;
    int         n_tests = 0, n_fail = 0;

    always_comb
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++)
                stored_regs[(p*4+r)*8 +: 8] = sreg[p][r];

    wcr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_pot(host_pot),
        .host_data(host_data), .xfer_ld(xfer_ld), .xfer_all(xfer_all),
        .xfer_pot(xfer_pot), .xfer_sel(xfer_sel), .step_en(step_en),
        .step_pot(step_pot), .step_pulse(step_pulse), .step_up(step_up),
        .stored_regs(stored_regs), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
    );

    // expected next state from the requirements
    task automatic model_next();
        logic [7:0] nx [4];
        bit ld;
        if (m_boot) begin                          // R1
            for (int p = 0; p < 4; p++) nx[p] = sreg[p][0];
            m_boot  = 1'b0;
            m_frame = 1'b0;
        end else begin
            for (int p = 0; p < 4; p++) begin
                ld = 1'b0;
                nx[p] = m_pos[p];
                if (host_wr && host_pot == 2'(p)) begin            // R3, R10
                    nx[p] = host_data; ld = 1'b1;
                end else if (xfer_ld && (xfer_all || xfer_pot == 2'(p))) begin // R4, R5
                    nx[p] = sreg[p][xfer_sel]; ld = 1'b1;
                end
                if (!ld && m_frame && step_pulse && m_fpot == 2'(p)) begin  // R6, R7, R9
                    if (step_up) nx[p] = (m_pos[p] == 8'hFF) ? 8'hFF : m_pos[p] + 8'd1;
                    else         nx[p] = (m_pos[p] == 8'h00) ? 8'h00 : m_pos[p] - 8'd1;
                end
            end
            if (m_frame) m_frame = step_en;                        // R8
            else if (step_en) begin m_frame = 1'b1; m_fpot = step_pot; end
        end
        for (int p = 0; p < 4; p++) m_pos[p] = nx[p];
    endtask

    task automatic check(string tag);
        logic [255:0] exp_tap;
        for (int p = 0; p < 4; p++) begin
            exp_tap = 256'b1 << m_pos[p];
            n_tests++;
            if (wiper_pos[p*8 +: 8] !== m_pos[p] || tap_sel[p*256 +: 256] !== exp_tap) begin
                n_fail++;
                $display("FAIL %s pot%0d: pos=%02h exp=%02h tap_ones=%0d tap_at_exp=%b",
                         tag, p, wiper_pos[p*8 +: 8], m_pos[p],
                         $countones(tap_sel[p*256 +: 256]), tap_sel[p*256 + int'(m_pos[p])]);
            end
        end
    endtask

    task automatic tick(string tag);
        model_next();
        @(posedge clk);
        @(negedge clk);
        check(tag);
        host_wr = 0; xfer_ld = 0; step_pulse = 0;
    endtask

    task automatic host(input logic [1:0] p, input logic [7:0] d);
        host_wr = 1; host_pot = p; host_data = d;
    endtask

    task automatic pulse(input bit up);
        step_pulse = 1; step_up = up;
    endtask

    function automatic logic [7:0] pick8();
        case ($urandom % 6)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h01;
            3: return 8'hFE;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int p = 0; p < 4; p++) begin
            m_pos[p] = 8'h00;
            for (int r = 0; r < 4; r++) sreg[p][r] = 8'(16*p + 4*r + 3);
        end
        repeat (3) @(negedge clk);
        check("R1 reset value");

        // R1: recall on first edge, a host write and transfer there are ignored
        rst_n = 1'b1;
        host(2'd0, 8'h55);
        xfer_ld = 1; xfer_all = 1; xfer_sel = 2'd2;
        tick("R1 power-up recall");
        xfer_all = 0;

        // R2: both range ends on the tap vector
        host(2'd0, 8'h00); tick("R2 tap low end");
        host(2'd1, 8'hFF); tick("R2 tap high end");

        // R3
        host(2'd2, 8'hA7); tick("R3 host write");

        // R4
        xfer_ld = 1; xfer_pot = 2'd3; xfer_sel = 2'd3; tick("R4 single transfer");

        // R5
        xfer_ld = 1; xfer_all = 1; xfer_sel = 2'd1; tick("R5 global transfer");
        xfer_all = 0;

        // R8: pulse outside a frame, and on the opening edge
        pulse(1); tick("R8 pulse in idle ignored");
        step_en = 1; step_pot = 2'd3; pulse(1); tick("R8 pulse on frame entry ignored");

        // R6
        pulse(1); tick("R6 step up");
        pulse(1); tick("R6 step up again");
        pulse(0); tick("R6 step down");
        step_pot = 2'd0; pulse(1); tick("R8 pot change mid-frame ignored");

        // R7
        host(2'd3, 8'hFF); tick("R7 preset top");
        pulse(1); tick("R7 saturate at FFh");
        host(2'd3, 8'h00); tick("R7 preset bottom");
        pulse(0); tick("R7 saturate at 00h");

        // R9
        host(2'd3, 8'h40); pulse(1); tick("R9 load beats step");
        xfer_ld = 1; xfer_pot = 2'd3; xfer_sel = 2'd0; pulse(0); tick("R9 transfer beats step");
        step_en = 0; tick("R6 frame close");

        // R10
        host(2'd1, 8'h3C); xfer_ld = 1; xfer_pot = 2'd1; xfer_sel = 2'd2;
        tick("R10 host beats transfer");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 16 == 0) sreg[$urandom % 4][$urandom % 4] = pick8();
            if ($urandom % 5 == 0) host(2'($urandom), pick8());
            if ($urandom % 5 == 0) begin
                xfer_ld = 1; xfer_all = ($urandom % 3 == 0);
                xfer_pot = 2'($urandom); xfer_sel = 2'($urandom);
            end
            if ($urandom % 20 == 0) step_en = ~step_en;
            step_pot = 2'($urandom);
            if ($urandom % 2 == 0) pulse(($urandom % 2) == 1);
            tick("random mix R3 R4 R5 R6 R7 R8 R9 R10");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule